// File: doc/BRIEF.md
# Master-to-Frame Clock Ratio Classifier and Stop Sequencer

This block sits at the front of an audio digital-to-analog datapath. It counts master clock cycles across each frame clock period and matches the count to one of the supported oversampling ratios. From that ratio it derives the speed class: normal, double or quad rate. It also watches both clocks for loss. The frame clock is timed in frame periods on the master clock. The master clock is timed by a free-running reference clock, because a stopped master clock cannot time itself.

A short sequencer turns these observations into the controls the datapath needs. Reset stays active while the ratio is unknown or unsupported, or while a clock is missing. Once a ratio is locked, the digital path is enabled after a fixed number of frames. After a settling interval that depends on the speed class, the output is marked valid. Any clock loss, unlock or ratio change drops the chain back to reset.

Top module: `fs_ratio_sense`

## Requirements
- R1: Measured ratios of 512, 768 and 1152 master cycles per frame report speedMode 0 (normal). Ratios of 256 and 384 report 1 (double). Ratios of 128 and 192 report 2 (quad). detRatio reports the matched nominal ratio, and once locked the chain ends with outValid high and rstActive low.
- R2: A count within plus or minus TOL (default 2) of a nominal ratio is matched to that ratio. A count one beyond that window is not matched.
- R3: A frame count that matches no supported ratio sets ratioBad to 1. It clears the lock, so detRatio reads 0 and speedMode reads 3, and it holds rstActive high with digEn low.
- R4: A new ratio takes effect only after two consecutive frames have measured it. A single frame of a different valid length leaves detRatio, speedMode and outValid unchanged.
- R5: When no frame clock rising edge arrives for more than STOP_FRAMES frame periods, rstActive is raised and digEn and outValid are dropped. This does not happen while the gap is below that limit.
- R6: After a frame clock stop, the first edge that arrives restarts measurement, and the block relocks without any other action.
- R7: When the reference clock sees no master clock toggle for SILENT_CYC cycles (default 64), rstActive is raised and digEn and outValid are forced low at once. Below that gap nothing changes. After the master clock resumes, the block relocks by itself.
- R8: The resume edge is counted as frame edge 1, and lock is reached at edge 3. digEn rises EN_FRAMES (default 2) frame edges after lock, at edge 5, and is low at edge 4.
- R9: outValid rises when SETTLE_BASE frames (normal), twice that (double) or four times that (quad) have passed after digEn rose. outValid is never high without digEn.
- R10: While rstN is low: rstActive is 1, digEn and outValid are 0, detRatio is 0 and speedMode is 3.
- R11: Once lock is lost, digEn is low from the next master clock cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock used to time master clock activity |
| rstN | input | 1 | Asynchronous active-low reset |
| masterClk | input | 1 | Master (oversampling) clock |
| frameClk | input | 1 | Frame (sample-rate) clock; a rising edge marks a frame boundary |
| detRatio | output | 12 | Locked master-cycles-per-frame ratio, 0 when unlocked |
| speedMode | output | 2 | 0 normal, 1 double, 2 quad, 3 none |
| ratioBad | output | 1 | Last frame measurement matched no supported ratio |
| digEn | output | 1 | Digital datapath enable |
| outValid | output | 1 | Output settled and valid |
| rstActive | output | 1 | Datapath held in reset with output forced to zero |

## Verification
The ratio classifier is first driven through a table of frame lengths: every supported ratio, the counts at the edges of the tolerance window, one count just outside it, and one far from any supported value. This separates correct speed classification from correct tolerance matching and from correct rejection. Several back-to-back ratio changes also check that a change of lock restarts the enable and settle chain. Directed patterns then insert one odd-length frame, stop the frame clock for gaps below and above the limit, and stop the master clock for gaps below and above the silence limit. Each tells the two-frame agreement, the stop thresholds and the recovery path apart. The recovery after a frame clock stop is sampled frame by frame, which pins down the enable and settling edges exactly.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  localparam int unsigned MAX_RATIO = 1152;
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO) + 1;

  typedef enum logic [2:0] {
    RC_NONE = 3'd0,
    RC_128  = 3'd1,
    RC_192  = 3'd2,
    RC_256  = 3'd3,
    RC_384  = 3'd4,
    RC_512  = 3'd5,
    RC_768  = 3'd6,
    RC_1152 = 3'd7
  } ratio_code_e;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_NONE   = 2'd3
  } speed_e;

  // Strobes from the measuring datapath to the sequencing control
  typedef struct packed {
    logic        frameTick;
    logic        locked;
    logic        lrStopped;
    ratio_code_e code;
  } meter_strobe_t;

  function automatic logic [CNT_W-1:0] ratioValue(input ratio_code_e c);
    logic [CNT_W-1:0] v;
    case (c)
      RC_128:  v = CNT_W'(128);
      RC_192:  v = CNT_W'(192);
      RC_256:  v = CNT_W'(256);
      RC_384:  v = CNT_W'(384);
      RC_512:  v = CNT_W'(512);
      RC_768:  v = CNT_W'(768);
      RC_1152: v = CNT_W'(1152);
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic speed_e speedOf(input ratio_code_e c);
    speed_e s;
    case (c)
      RC_128, RC_192:          s = SPD_QUAD;
      RC_256, RC_384:          s = SPD_DOUBLE;
      RC_512, RC_768, RC_1152: s = SPD_NORMAL;
      default:                 s = SPD_NONE;
    endcase
    return s;
  endfunction

  function automatic ratio_code_e classify(input logic [CNT_W-1:0] m, input int unsigned tol);
    ratio_code_e r;
    int unsigned mv;
    int unsigned nom;
    r  = RC_NONE;
    mv = 32'(m);
    for (int i = 1; i < 8; i++) begin
      nom = 32'(ratioValue(ratio_code_e'(3'(i))));
      if ((mv + tol >= nom) && (mv <= nom + tol)) r = ratio_code_e'(3'(i));
    end
    return r;
  endfunction

endpackage

// File: rtl/fsr_mclk_watch.sv
module fsr_mclk_watch #(
  parameter int unsigned SILENT_CYC    = 64,
  parameter int unsigned REARM_TOGGLES = 16
) (
  input  logic refClk,
  input  logic rstN,
  input  logic masterClk,
  output logic mclkLost
);
  localparam int unsigned SIL_W = $clog2(SILENT_CYC + 1);
  localparam int unsigned ARM_W = $clog2(REARM_TOGGLES + 1);

  logic [2:0]       mSync;
  logic             toggleSeen;
  logic [SIL_W-1:0] silentCnt;
  logic [ARM_W-1:0] rearmCnt;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) mSync <= '0;
    else       mSync <= {mSync[1:0], masterClk};
  end

  assign toggleSeen = mSync[1] ^ mSync[2];

  // Starts lost: the master clock must prove itself after reset
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      mclkLost  <= 1'b1;
      silentCnt <= '0;
      rearmCnt  <= '0;
    end else if (!mclkLost) begin
      if (toggleSeen) begin
        silentCnt <= '0;
      end else if (silentCnt == SIL_W'(SILENT_CYC - 1)) begin
        mclkLost  <= 1'b1;
        silentCnt <= '0;
        rearmCnt  <= '0;
      end else begin
        silentCnt <= silentCnt + 1'b1;
      end
    end else if (toggleSeen) begin
      if (rearmCnt == ARM_W'(REARM_TOGGLES - 1)) begin
        mclkLost  <= 1'b0;
        silentCnt <= '0;
      end else begin
        rearmCnt <= rearmCnt + 1'b1;
      end
    end
  end

  AST_LOSS_NEEDS_SILENCE: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(mclkLost) |-> $past(!toggleSeen)); // R7

endmodule

// File: rtl/fsr_ratio_meter.sv
module fsr_ratio_meter
  import fsr_pkg::*;
#(
  parameter int unsigned TOL         = 2,
  parameter int unsigned STOP_FRAMES = 2048
) (
  input  logic          masterClk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          frameClk,
  output meter_strobe_t strb,
  output logic          ratioBad
);
  localparam int unsigned UNLOCK_LEN = MAX_RATIO + TOL + 2;
  localparam int unsigned MISS_W     = $clog2(STOP_FRAMES + 2);

  logic [2:0]        lrSync;
  logic              tick;
  logic [CNT_W-1:0]  periodCnt;
  logic [CNT_W-1:0]  measured;
  logic [CNT_W-1:0]  subCnt;
  logic [CNT_W-1:0]  frameLast;
  logic [MISS_W-1:0] missed;
  logic              armed;
  logic              stopped;
  logic              locked;
  ratio_code_e       curCode;
  ratio_code_e       prevCode;
  ratio_code_e       lockedCode;

  always_ff @(posedge masterClk or negedge rstN) begin
    if (!rstN) lrSync <= '0;
    else       lrSync <= {lrSync[1:0], frameClk};
  end

  assign tick      = lrSync[1] & ~lrSync[2];
  assign measured  = (periodCnt == '1) ? periodCnt : periodCnt + 1'b1;
  assign curCode   = classify(measured, TOL);
  assign frameLast = locked ? ratioValue(lockedCode) - 1'b1 : CNT_W'(UNLOCK_LEN - 1);

  always_ff @(posedge masterClk or negedge rstN) begin
    if (!rstN) begin
      periodCnt  <= '0;
      subCnt     <= '0;
      missed     <= '0;
      armed      <= 1'b0;
      stopped    <= 1'b0;
      locked     <= 1'b0;
      ratioBad   <= 1'b0;
      prevCode   <= RC_NONE;
      lockedCode <= RC_NONE;
    end else if (clr) begin
      periodCnt  <= '0;
      subCnt     <= '0;
      missed     <= '0;
      armed      <= 1'b0;
      stopped    <= 1'b0;
      locked     <= 1'b0;
      ratioBad   <= 1'b0;
      prevCode   <= RC_NONE;
      lockedCode <= RC_NONE;
    end else if (tick) begin
      periodCnt <= '0;
      subCnt    <= '0;
      missed    <= '0;
      stopped   <= 1'b0;
      armed     <= 1'b1;
      if (armed) begin
        ratioBad <= (curCode == RC_NONE);
        prevCode <= curCode;
        if (curCode == RC_NONE) begin
          locked <= 1'b0;
        end else if (curCode == prevCode) begin
          locked     <= 1'b1;
          lockedCode <= curCode;
        end
      end
    end else begin
      if (periodCnt != '1) periodCnt <= periodCnt + 1'b1;
      if (subCnt >= frameLast) begin
        subCnt <= '0;
        if (missed != '1) missed <= missed + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
      if (32'(missed) > STOP_FRAMES) begin
        stopped  <= 1'b1;
        locked   <= 1'b0;
        armed    <= 1'b0;
        prevCode <= RC_NONE;
      end
    end
  end

  assign strb.frameTick = tick;
  assign strb.locked    = locked;
  assign strb.lrStopped = stopped;
  assign strb.code      = lockedCode;

  AST_STOP_DROPS_LOCK: assert property (@(posedge masterClk) disable iff (!rstN)
    stopped |-> !locked); // R5

  AST_LOCK_ON_FRAME_EDGE: assert property (@(posedge masterClk) disable iff (!rstN)
    $rose(locked) |-> $past(lrSync[1] & ~lrSync[2])); // R4

  AST_BAD_NOT_LOCKED: assert property (@(posedge masterClk) disable iff (!rstN)
    $rose(ratioBad) |-> !locked); // R3

endmodule

// File: rtl/fsr_pwr_seq.sv
module fsr_pwr_seq
  import fsr_pkg::*;
#(
  parameter int unsigned EN_FRAMES   = 2,
  parameter int unsigned SETTLE_BASE = 64
) (
  input  logic          masterClk,
  input  logic          rstN,
  input  logic          clr,
  input  meter_strobe_t strb,
  output logic          digEn,
  output logic          outValid,
  output logic          rstActive
);
  localparam int unsigned SEQ_W = $clog2(SETTLE_BASE * 4 + EN_FRAMES + 1);

  typedef enum logic [1:0] {ST_HOLD, ST_ENWAIT, ST_SETTLE, ST_RUN} seq_state_e;

  seq_state_e       state;
  ratio_code_e      heldCode;
  logic [SEQ_W-1:0] frameCnt;
  logic [SEQ_W-1:0] settleLast;
  logic             abortSeq;

  always_comb begin
    case (speedOf(heldCode))
      SPD_DOUBLE: settleLast = SEQ_W'(SETTLE_BASE * 2 - 1);
      SPD_QUAD:   settleLast = SEQ_W'(SETTLE_BASE * 4 - 1);
      default:    settleLast = SEQ_W'(SETTLE_BASE - 1);
    endcase
  end

  assign abortSeq = !strb.locked || strb.lrStopped || (strb.code != heldCode);

  always_ff @(posedge masterClk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HOLD;
      heldCode <= RC_NONE;
      frameCnt <= '0;
    end else if (clr) begin
      state    <= ST_HOLD;
      heldCode <= RC_NONE;
      frameCnt <= '0;
    end else if (state == ST_HOLD) begin
      if (strb.locked && !strb.lrStopped) begin
        state    <= ST_ENWAIT;
        heldCode <= strb.code;
        frameCnt <= '0;
      end
    end else if (abortSeq) begin
      state <= ST_HOLD;
    end else if (strb.frameTick) begin
      case (state)
        ST_ENWAIT: begin
          if (frameCnt == SEQ_W'(EN_FRAMES - 1)) begin
            state    <= ST_SETTLE;
            frameCnt <= '0;
          end else begin
            frameCnt <= frameCnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (frameCnt == settleLast) state <= ST_RUN;
          else                        frameCnt <= frameCnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign rstActive = (state == ST_HOLD);
  assign digEn     = (state == ST_SETTLE) || (state == ST_RUN);
  assign outValid  = (state == ST_RUN);

  AST_UNLOCK_DROPS_EN: assert property (@(posedge masterClk) disable iff (!rstN)
    !strb.locked |=> !digEn); // R11

  AST_STOP_DROPS_EN: assert property (@(posedge masterClk) disable iff (!rstN)
    strb.lrStopped |=> !digEn); // R5

  AST_VALID_AFTER_EN: assert property (@(posedge masterClk) disable iff (!rstN)
    $rose(outValid) |-> $past(digEn)); // R9

endmodule

// File: rtl/fs_ratio_sense.sv
module fs_ratio_sense
  import fsr_pkg::*;
#(
  parameter int unsigned TOL           = 2,
  parameter int unsigned STOP_FRAMES   = 2048,
  parameter int unsigned EN_FRAMES     = 2,
  parameter int unsigned SETTLE_BASE   = 64,
  parameter int unsigned SILENT_CYC    = 64,
  parameter int unsigned REARM_TOGGLES = 16
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              masterClk,
  input  logic              frameClk,
  output logic [CNT_W-1:0]  detRatio,
  output logic [1:0]        speedMode,
  output logic              ratioBad,
  output logic              digEn,
  output logic              outValid,
  output logic              rstActive
);
  logic          mclkLost;
  logic [1:0]    lostSyncM;
  logic          clrM;
  meter_strobe_t strb;
  logic          seqEn;
  logic          seqValid;
  logic          seqRst;

  fsr_mclk_watch #(
    .SILENT_CYC   (SILENT_CYC),
    .REARM_TOGGLES(REARM_TOGGLES)
  ) watch_i (
    .refClk   (refClk),
    .rstN     (rstN),
    .masterClk(masterClk),
    .mclkLost (mclkLost)
  );

  // Bring the loss flag into the master domain to clear its state on return
  always_ff @(posedge masterClk or negedge rstN) begin
    if (!rstN) lostSyncM <= 2'b11;
    else       lostSyncM <= {lostSyncM[0], mclkLost};
  end
  assign clrM = lostSyncM[1];

  fsr_ratio_meter #(
    .TOL        (TOL),
    .STOP_FRAMES(STOP_FRAMES)
  ) meter_i (
    .masterClk(masterClk),
    .rstN     (rstN),
    .clr      (clrM),
    .frameClk (frameClk),
    .strb     (strb),
    .ratioBad (ratioBad)
  );

  fsr_pwr_seq #(
    .EN_FRAMES  (EN_FRAMES),
    .SETTLE_BASE(SETTLE_BASE)
  ) seq_i (
    .masterClk(masterClk),
    .rstN     (rstN),
    .clr      (clrM),
    .strb     (strb),
    .digEn    (seqEn),
    .outValid (seqValid),
    .rstActive(seqRst)
  );

  assign detRatio  = strb.locked ? ratioValue(strb.code) : '0;
  assign speedMode = strb.locked ? speedOf(strb.code) : SPD_NONE;
  assign rstActive = seqRst | mclkLost;
  assign digEn     = seqEn & ~mclkLost;
  assign outValid  = seqValid & ~mclkLost;

endmodule

// File: tb/fs_ratio_sense_tb_top.sv
`timescale 1ns/1ps
module fs_ratio_sense_tb_top;

  localparam int NVEC = 11;
  // frame length, expected ratio, expected speed, expected bad flag
  localparam int VR [NVEC] = '{128, 192, 256, 384, 512, 768, 1152, 130, 126, 131, 300};
  localparam int VE [NVEC] = '{128, 192, 256, 384, 512, 768, 1152, 128, 128,   0,   0};
  localparam int VS [NVEC] = '{  2,   2,   1,   1,   0,   0,    0,   2,   2,   3,   3};
  localparam int VB [NVEC] = '{  0,   0,   0,   0,   0,   0,    0,   0,   0,   1,   1};

  logic        refClk = 1'b0;
  logic        rstN = 1'b0;
  logic        masterClk = 1'b0;
  logic        frameClk;
  logic [11:0] detRatio;
  logic [1:0]  speedMode;
  logic        ratioBad;
  logic        digEn;
  logic        outValid;
  logic        rstActive;

  logic mclkRun = 1'b1;
  logic lrRun = 1'b1;
  int   benchRatio = 128;
  int   curRatio = 128;
  int   genCnt = 0;
  int   nChecks = 0;
  int   nFails = 0;
  int   wdCnt = 0;
  int   edgeNum = 0;

  always #4 refClk = ~refClk;
  always begin
    #5;
    if (mclkRun) masterClk = ~masterClk;
  end

  always @(negedge masterClk) begin
    if (!lrRun) begin
      genCnt   <= 0;
      curRatio <= benchRatio;
    end else if (genCnt >= curRatio - 1) begin
      genCnt   <= 0;
      curRatio <= benchRatio;
    end else begin
      genCnt <= genCnt + 1;
    end
  end
  assign frameClk = lrRun && (genCnt < curRatio / 2);

  fs_ratio_sense #(
    .STOP_FRAMES(8),
    .SETTLE_BASE(2)
  ) dut_i (
    .refClk   (refClk),
    .rstN     (rstN),
    .masterClk(masterClk),
    .frameClk (frameClk),
    .detRatio (detRatio),
    .speedMode(speedMode),
    .ratioBad (ratioBad),
    .digEn    (digEn),
    .outValid (outValid),
    .rstActive(rstActive)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mclkWait(input int n);
    repeat (n) @(posedge masterClk);
    #2;
  endtask

  // advance to frame edge k (counted from resume) and sample mid-frame
  task automatic toEdge(input int k);
    while (edgeNum < k) begin
      @(posedge frameClk);
      edgeNum++;
    end
    mclkWait(64);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge refClk) begin
    wdCnt++;
    if (wdCnt == 190000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected 0", wdCnt);
      finishRun();
    end
  end

  initial begin
    // R10: reset state
    repeat (20) @(posedge refClk);
    #2;
    chk("R10", "rstActive", int'(rstActive), 1);
    chk("R10", "digEn", int'(digEn), 0);
    chk("R10", "outValid", int'(outValid), 0);
    chk("R10", "detRatio", int'(detRatio), 0);
    chk("R10", "speedMode", int'(speedMode), 3);
    rstN = 1'b1;

    // R1, R2, R3: ratio table
    for (int i = 0; i < NVEC; i++) begin
      benchRatio = VR[i];
      @(posedge frameClk);
      mclkWait(18 * VR[i]);
      chk(VB[i] != 0 ? "R3" : (VR[i] == VE[i] ? "R1" : "R2"), "detRatio", int'(detRatio), VE[i]);
      chk(VB[i] != 0 ? "R3" : "R1", "speedMode", int'(speedMode), VS[i]);
      chk(VB[i] != 0 ? "R3" : "R2", "ratioBad", int'(ratioBad), VB[i]);
      chk(VB[i] != 0 ? "R3" : "R1", "rstActive", int'(rstActive), VB[i]);
      chk(VB[i] != 0 ? "R3" : "R1", "outValid", int'(outValid), 1 - VB[i]);
      chk(VB[i] != 0 ? "R3" : "R1", "digEn", int'(digEn), 1 - VB[i]);
    end

    // back to quad 128 and settle
    benchRatio = 128;
    @(posedge frameClk);
    mclkWait(18 * 128);
    chk("R1", "detRatio back", int'(detRatio), 128);

    // R4: one odd frame of 192 is ignored
    benchRatio = 192;
    @(posedge frameClk);
    benchRatio = 128;
    @(posedge frameClk);
    @(posedge frameClk);
    mclkWait(64);
    chk("R4", "detRatio after odd frame", int'(detRatio), 128);
    chk("R4", "outValid after odd frame", int'(outValid), 1);
    mclkWait(3 * 128);
    chk("R4", "speedMode later", int'(speedMode), 2);
    chk("R4", "outValid later", int'(outValid), 1);

    // R5: frame clock stop, below then above limit
    @(negedge masterClk);
    #1 lrRun = 1'b0;
    mclkWait(6 * 128);
    chk("R5", "rstActive short gap", int'(rstActive), 0);
    chk("R5", "outValid short gap", int'(outValid), 1);
    mclkWait(6 * 128);
    chk("R5", "rstActive long gap", int'(rstActive), 1);
    chk("R5", "digEn long gap", int'(digEn), 0);
    chk("R5", "outValid long gap", int'(outValid), 0);

    // R6, R8, R9: resume and count edges
    @(negedge masterClk);
    #1 lrRun = 1'b1;
    edgeNum = 1;
    mclkWait(64);
    chk("R6", "rstActive at edge 1", int'(rstActive), 1);
    toEdge(4);
    chk("R8", "digEn at edge 4", int'(digEn), 0);
    chk("R6", "rstActive at edge 4", int'(rstActive), 0);
    toEdge(5);
    chk("R8", "digEn at edge 5", int'(digEn), 1);
    chk("R9", "outValid at edge 5", int'(outValid), 0);
    toEdge(12);
    chk("R9", "outValid at edge 12", int'(outValid), 0);
    toEdge(13);
    chk("R9", "outValid at edge 13", int'(outValid), 1);
    chk("R6", "detRatio after resume", int'(detRatio), 128);

    // R7: master clock stop, below then above silence limit
    @(posedge refClk);
    mclkRun = 1'b0;
    repeat (40) @(posedge refClk);
    #2;
    chk("R7", "rstActive short silence", int'(rstActive), 0);
    chk("R7", "outValid short silence", int'(outValid), 1);
    repeat (40) @(posedge refClk);
    #2;
    chk("R7", "rstActive long silence", int'(rstActive), 1);
    chk("R7", "digEn long silence", int'(digEn), 0);
    chk("R7", "outValid long silence", int'(outValid), 0);
    mclkRun = 1'b1;
    mclkWait(20 * 128);
    chk("R7", "outValid after return", int'(outValid), 1);
    chk("R7", "rstActive after return", int'(rstActive), 0);
    chk("R7", "detRatio after return", int'(detRatio), 128);

    finishRun();
  end

endmodule